// File: doc/BRIEF.md
# Gated Sixteen-Bit Event Counter with Prescaler

This block is a 16-bit up-counter for long interval timing. Its count source is either every system clock cycle or one cycle in four. A 1:1 to 1:8 prescaler follows the count source. A gate can restrict counting to the time a chosen signal sits at its active level. The gate signal is either an external pin or the single-cycle period-match pulse of a companion timer, so the counter can total match events from that timer.

Software reads and writes the counter one byte at a time. When buffered access is enabled, reading the low byte also latches the high byte, and writing the high byte only loads a holding register. The later low-byte write then moves the whole 16-bit value into the counter at once. A sticky overflow flag marks each wrap from all-ones to zero and, when unmasked, drives an interrupt request.

Top module: `gated_count16`

## Requirements
- R1: After reset the count is 0x0000 and `ovf_flag`, `irq`, `rdata_lo` and `rdata_hi` are all zero.
- R2: `cfg_clksrc` picks the count source. 2'b00 gives one tick every fourth system clock, 2'b01 gives a tick on every system clock, and 2'b10 or 2'b11 give no ticks, so the count holds.
- R3: `cfg_psc` sets how many ticks make one count step. 2'b00 is 1, 2'b01 is 2, 2'b10 is 4 and 2'b11 is 8.
- R4: While `cfg_gate_en` is 1, ticks count only when the gate signal equals `cfg_gate_pol` (1 = active high, 0 = active low). While `cfg_gate_en` is 0, the gate signal has no effect.
- R5: `cfg_gate_src` picks the gate signal. 2'b00 selects `gate_pin`, 2'b01 selects `peer_match`, and 2'b10 or 2'b11 select a constant 0. A single-cycle `peer_match` pulse with an active-high gate and a 1:1 source yields exactly one step.
- R6: The gate signal passes through two flip-flops. A gate edge driven before clock edge k first affects the step taken at edge k+2.
- R7: `ovf_flag` sets only on a step from 0xFFFF to 0x0000. It stays set until an `ovf_clr` pulse clears it. A wrap in the same cycle as `ovf_clr` leaves the flag set.
- R8: `irq` is high exactly when `ovf_flag` and `cfg_irq_en` are both 1.
- R9: While `cfg_on` is 0, the count and the prescaler state hold and no overflow occurs.
- R10: Any write that changes the counter resets the prescaler to zero. In the same cycle the write takes priority over a count step.
- R11: With `cfg_rd16` = 1, a `rd_lo` pulse latches the high byte as it stands in that cycle. `rdata_hi` shows the latched byte until the next `rd_lo` pulse.
- R12: With `cfg_rd16` = 1, `wr_hi` loads only a holding byte and leaves the counter unchanged. `wr_lo` loads {holding byte, `bus_wdata`} into the counter in one cycle.
- R13: With `cfg_rd16` = 0, `wr_hi` and `wr_lo` each write their own byte of the counter directly, and `rdata_hi` shows the live high byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_on | input | 1 | Run enable |
| cfg_clksrc | input | 2 | Count source select |
| cfg_psc | input | 2 | Prescale ratio select |
| cfg_gate_en | input | 1 | Gate enable |
| cfg_gate_pol | input | 1 | Gate active level |
| cfg_gate_src | input | 2 | Gate signal select |
| cfg_rd16 | input | 1 | Buffered 16-bit access enable |
| cfg_irq_en | input | 1 | Interrupt mask |
| gate_pin | input | 1 | External gate level |
| peer_match | input | 1 | Companion timer period-match pulse |
| bus_wdata | input | 8 | Write data byte |
| wr_lo | input | 1 | Low byte write strobe |
| wr_hi | input | 1 | High byte write strobe |
| rd_lo | input | 1 | Low byte read strobe |
| ovf_clr | input | 1 | Overflow flag clear strobe |
| rdata_lo | output | 8 | Live low byte of the count |
| rdata_hi | output | 8 | High byte, latched or live |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
A table of settings runs a 64-cycle window after the counter is cleared. The settings cover both count sources, all four prescale ratios, both unused source codes, each gate source with both polarities at static levels, and a disabled gate with an inactive pin. Because each ratio and each source gives a different final count, the table separates a swapped ratio, an inverted polarity, a wrong source select and a gate that is not ignored when disabled. Directed runs send isolated peer pulses, which show that each pulse gives exactly one step. They also raise the pin one edge at a time to expose the synchronizer latency, and write mid-prescale to show that the prescaler is cleared. Further runs wrap from 0xFFFE and clear the flag in the wrap cycle, and step through buffered byte access so that stale and refreshed high bytes can be told apart.

// File: rtl/gc16_pkg.sv
package gc16_pkg;
  localparam logic [1:0] CS_QUARTER = 2'b00;
  localparam logic [1:0] CS_FULL    = 2'b01;
  localparam logic [1:0] GS_PIN     = 2'b00;
  localparam logic [1:0] GS_PEER    = 2'b01;
endpackage

// File: rtl/gc16_tickgen.sv
module gc16_tickgen #(
  parameter int DIV_LOG2 = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] src,
  output logic       tick
);
  import gc16_pkg::*;

  logic [DIV_LOG2-1:0] div_q, div_d;

  always_comb begin
    div_d = div_q;
    if (run) div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  always_comb begin
    case (src)
      CS_QUARTER: tick = run & (&div_q);
      CS_FULL:    tick = run;
      default:    tick = 1'b0;
    endcase
  end
endmodule

// File: rtl/gc16_gate.sv
module gc16_gate #(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       pol,
  input  logic [1:0] src,
  input  logic       pin,
  input  logic       peer,
  output logic       open
);
  import gc16_pkg::*;

  logic              raw;
  logic [STAGES-1:0] sync_q, sync_d;

  always_comb begin
    case (src)
      GS_PIN:  raw = pin;
      GS_PEER: raw = peer;
      default: raw = 1'b0;
    endcase
  end

  assign sync_d[0] = raw;
  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    assign sync_d[i] = sync_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign open = ~en | ~(sync_q[STAGES-1] ^ pol);
endmodule

// File: rtl/gc16_prescale.sv
module gc16_prescale #(
  parameter int PW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          clear,
  input  logic [PW-1:0] ratio_sel,
  output logic          step
);
  localparam int QW = (1 << PW) - 1;

  logic [QW-1:0] pq_q, pq_d, lim;

  assign lim  = ({{(QW-1){1'b0}}, 1'b1} << ratio_sel) - 1'b1;
  assign step = tick & (pq_q == lim);

  always_comb begin
    pq_d = pq_q;
    if (clear)     pq_d = '0;
    else if (step) pq_d = '0;
    else if (tick) pq_d = pq_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pq_q <= '0;
    else        pq_q <= pq_d;
  end
endmodule

// File: rtl/gated_count16.sv
module gated_count16 #(
  parameter int BW          = 8,
  parameter int PW          = 2,
  parameter int SYNC_STAGES = 2,
  parameter int DIV_LOG2    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_on,
  input  logic [1:0]    cfg_clksrc,
  input  logic [PW-1:0] cfg_psc,
  input  logic          cfg_gate_en,
  input  logic          cfg_gate_pol,
  input  logic [1:0]    cfg_gate_src,
  input  logic          cfg_rd16,
  input  logic          cfg_irq_en,
  input  logic          gate_pin,
  input  logic          peer_match,
  input  logic [BW-1:0] bus_wdata,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic          rd_lo,
  input  logic          ovf_clr,
  output logic [BW-1:0] rdata_lo,
  output logic [BW-1:0] rdata_hi,
  output logic          ovf_flag,
  output logic          irq
);
  localparam int CW = 2 * BW;

  logic [1:0]    rst_pipe_q;
  logic          rst_q;
  logic          raw_tick, gate_open, step;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [BW-1:0] wbuf_q, wbuf_d, rbuf_q, rbuf_d;
  logic          flag_q, flag_d;
  logic          wrote, wrap;

  // Reset asserts at once and releases two edges later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_q = rst_pipe_q[1];

  gc16_tickgen #(.DIV_LOG2(DIV_LOG2)) u_tick (
    .clk  (clk),
    .rst_n(rst_q),
    .run  (cfg_on),
    .src  (cfg_clksrc),
    .tick (raw_tick)
  );

  gc16_gate #(.STAGES(SYNC_STAGES)) u_gate (
    .clk  (clk),
    .rst_n(rst_q),
    .en   (cfg_gate_en),
    .pol  (cfg_gate_pol),
    .src  (cfg_gate_src),
    .pin  (gate_pin),
    .peer (peer_match),
    .open (gate_open)
  );

  assign wrote = wr_lo | (wr_hi & ~cfg_rd16);

  gc16_prescale #(.PW(PW)) u_psc (
    .clk      (clk),
    .rst_n    (rst_q),
    .tick     (raw_tick & gate_open),
    .clear    (wrote),
    .ratio_sel(cfg_psc),
    .step     (step)
  );

  assign wrap = step & ~wrote & (&cnt_q);

  always_comb begin
    cnt_d  = cnt_q;
    wbuf_d = wbuf_q;
    rbuf_d = rbuf_q;
    if (cfg_rd16) begin
      if (wr_hi) wbuf_d = bus_wdata;
      if (wr_lo) cnt_d  = {wbuf_q, bus_wdata};
    end else begin
      if (wr_hi) cnt_d[CW-1:BW] = bus_wdata;
      if (wr_lo) cnt_d[BW-1:0]  = bus_wdata;
    end
    if (!wrote && step) cnt_d = cnt_q + 1'b1;
    if (rd_lo) rbuf_d = cnt_q[CW-1:BW];
  end

  always_comb begin
    flag_d = flag_q;
    if (wrap)         flag_d = 1'b1;
    else if (ovf_clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      cnt_q  <= '0;
      wbuf_q <= '0;
      rbuf_q <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      wbuf_q <= wbuf_d;
      rbuf_q <= rbuf_d;
      flag_q <= flag_d;
    end
  end

  assign rdata_lo = cnt_q[BW-1:0];
  assign rdata_hi = cfg_rd16 ? rbuf_q : cnt_q[CW-1:BW];
  assign ovf_flag = flag_q;
  assign irq      = flag_q & cfg_irq_en;
endmodule

// File: rtl/gc16_chk.sv
module gc16_chk #(
  parameter int CW = 16,
  parameter int BW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_on,
  input logic [1:0]    cfg_clksrc,
  input logic          wr_lo,
  input logic          wr_hi,
  input logic          rd_lo,
  input logic          ovf_clr,
  input logic          ovf_flag,
  input logic          irq,
  input logic [CW-1:0] cnt,
  input logic [BW-1:0] rbuf
);
  // R7
  ovf_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> ($past(cnt) == {CW{1'b1}}) && (cnt == '0));

  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);

  // R9
  off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_on && !wr_lo && !wr_hi) |=> $stable(cnt));

  // R2
  nosrc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_clksrc[1] && !wr_lo && !wr_hi) |=> $stable(cnt));

  // R3
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_lo && !wr_hi) |=> (cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1));

  // R11
  rbuf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_lo |=> $stable(rbuf));

  // R8
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ovf_flag);
endmodule

bind gated_count16 gc16_chk #(.CW(CW), .BW(BW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_q),
  .cfg_on    (cfg_on),
  .cfg_clksrc(cfg_clksrc),
  .wr_lo     (wr_lo),
  .wr_hi     (wr_hi),
  .rd_lo     (rd_lo),
  .ovf_clr   (ovf_clr),
  .ovf_flag  (ovf_flag),
  .irq       (irq),
  .cnt       (cnt_q),
  .rbuf      (rbuf_q)
);

// File: tb/gated_count16_test.sv
module gated_count16_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_on, cfg_gate_en, cfg_gate_pol, cfg_rd16, cfg_irq_en;
  logic [1:0] cfg_clksrc, cfg_psc, cfg_gate_src;
  logic       gate_pin, peer_match, wr_lo, wr_hi, rd_lo, ovf_clr;
  logic [7:0] bus_wdata, rdata_lo, rdata_hi;
  logic       ovf_flag, irq;
  int         n_run = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  gated_count16 uut (
    .clk(clk), .rst_n(rst_n), .cfg_on(cfg_on), .cfg_clksrc(cfg_clksrc),
    .cfg_psc(cfg_psc), .cfg_gate_en(cfg_gate_en), .cfg_gate_pol(cfg_gate_pol),
    .cfg_gate_src(cfg_gate_src), .cfg_rd16(cfg_rd16), .cfg_irq_en(cfg_irq_en),
    .gate_pin(gate_pin), .peer_match(peer_match), .bus_wdata(bus_wdata),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .rd_lo(rd_lo), .ovf_clr(ovf_clr),
    .rdata_lo(rdata_lo), .rdata_hi(rdata_hi), .ovf_flag(ovf_flag), .irq(irq)
  );

  typedef struct packed {
    logic [1:0]  cs;
    logic [1:0]  ps;
    logic        ge;
    logic        gp;
    logic [1:0]  gs;
    logic        pin;
    logic        peer;
    logic [15:0] exp;
  } vec_t;

  localparam int WIN = 64;
  localparam vec_t VECS [16] = '{
    '{2'b01, 2'd0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 16'd64},
    '{2'b00, 2'd0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 16'd16},
    '{2'b01, 2'd1, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 16'd32},
    '{2'b01, 2'd2, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 16'd16},
    '{2'b01, 2'd3, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 16'd8},
    '{2'b00, 2'd3, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 16'd2},
    '{2'b10, 2'd0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 16'd0},
    '{2'b11, 2'd0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 16'd0},
    '{2'b01, 2'd0, 1'b1, 1'b1, 2'b00, 1'b0, 1'b0, 16'd0},
    '{2'b01, 2'd0, 1'b1, 1'b1, 2'b00, 1'b1, 1'b0, 16'd64},
    '{2'b01, 2'd0, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 16'd64},
    '{2'b01, 2'd0, 1'b1, 1'b0, 2'b00, 1'b1, 1'b0, 16'd0},
    '{2'b01, 2'd0, 1'b1, 1'b1, 2'b01, 1'b0, 1'b1, 16'd64},
    '{2'b01, 2'd0, 1'b1, 1'b1, 2'b10, 1'b1, 1'b1, 16'd0},
    '{2'b01, 2'd0, 1'b1, 1'b0, 2'b11, 1'b1, 1'b1, 16'd64},
    '{2'b01, 2'd0, 1'b0, 1'b1, 2'b00, 1'b0, 1'b0, 16'd64}
  };

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] count_now();
    return {rdata_hi, rdata_lo};
  endfunction

  task automatic load(input logic [15:0] v);
    wr_hi = 1'b1; bus_wdata = v[15:8];
    cyc(1);
    wr_hi = 1'b0; wr_lo = 1'b1; bus_wdata = v[7:0];
    cyc(1);
    wr_lo = 1'b0;
  endtask

  task automatic base_cfg();
    cfg_on = 1'b1; cfg_clksrc = 2'b01; cfg_psc = 2'd0; cfg_gate_en = 1'b0;
    cfg_gate_pol = 1'b1; cfg_gate_src = 2'b00; cfg_rd16 = 1'b0;
    gate_pin = 1'b0; peer_match = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog all actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    base_cfg();
    cfg_on = 1'b0; cfg_irq_en = 1'b0;
    bus_wdata = '0; wr_lo = 1'b0; wr_hi = 1'b0; rd_lo = 1'b0; ovf_clr = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
    // R1 reset state
    chk("R1 count", count_now(), 16'h0000);
    chk("R1 flag/irq", {14'd0, ovf_flag, irq}, 16'h0000);

    // R2 R3 R4 R5 table
    for (int i = 0; i < 16; i++) begin
      base_cfg();
      cfg_clksrc = VECS[i].cs; cfg_psc = VECS[i].ps; cfg_gate_en = VECS[i].ge;
      cfg_gate_pol = VECS[i].gp; cfg_gate_src = VECS[i].gs;
      gate_pin = VECS[i].pin; peer_match = VECS[i].peer;
      cyc(4);
      load(16'h0000);
      cyc(WIN);
      chk((i < 8) ? "R2 R3 table" : "R4 R5 table", count_now(), VECS[i].exp);
    end

    // R6 synchronizer latency
    base_cfg(); cfg_gate_en = 1'b1;
    cyc(4);
    load(16'h0000);
    gate_pin = 1'b1;
    cyc(2);
    chk("R6 before", count_now(), 16'h0000);
    cyc(1);
    chk("R6 after", count_now(), 16'h0001);

    // R5 isolated peer pulses
    base_cfg(); cfg_gate_en = 1'b1; cfg_gate_src = 2'b01;
    cyc(4);
    load(16'h0000);
    for (int p = 0; p < 5; p++) begin
      peer_match = 1'b1; cyc(1);
      peer_match = 1'b0; cyc(5);
    end
    cyc(4);
    chk("R5 peer pulses", count_now(), 16'h0005);

    // R7 R8 overflow
    base_cfg();
    load(16'hFFFE);
    cyc(1);
    chk("R7 no flag at FFFF", {15'd0, ovf_flag}, 16'h0000);
    cyc(1);
    chk("R7 wrap count", count_now(), 16'h0000);
    chk("R7 flag set", {15'd0, ovf_flag}, 16'h0001);
    chk("R8 masked", {15'd0, irq}, 16'h0000);
    cfg_irq_en = 1'b1;
    #1;
    chk("R8 unmasked", {15'd0, irq}, 16'h0001);
    cyc(20);
    chk("R7 sticky", {15'd0, ovf_flag}, 16'h0001);
    ovf_clr = 1'b1; cyc(1); ovf_clr = 1'b0;
    chk("R7 cleared", {14'd0, ovf_flag, irq}, 16'h0000);
    load(16'hFFFF);
    ovf_clr = 1'b1; cyc(1); ovf_clr = 1'b0;
    chk("R7 set beats clear", {15'd0, ovf_flag}, 16'h0001);
    ovf_clr = 1'b1; cyc(1); ovf_clr = 1'b0;
    cfg_irq_en = 1'b0;

    // R9 timer off
    cfg_on = 1'b0;
    load(16'hFFFF);
    cyc(30);
    chk("R9 hold count", count_now(), 16'hFFFF);
    chk("R9 no flag", {15'd0, ovf_flag}, 16'h0000);
    cfg_on = 1'b1; cfg_psc = 2'd2;
    load(16'h0000);
    cyc(2);
    cfg_on = 1'b0;
    cyc(10);
    cfg_on = 1'b1;
    cyc(1);
    chk("R9 psc held a", count_now(), 16'h0000);
    cyc(1);
    chk("R9 psc held b", count_now(), 16'h0001);

    // R10 write clears prescaler and beats a step
    base_cfg(); cfg_psc = 2'd3;
    load(16'h0000);
    cyc(3);
    load(16'h0100);
    cyc(7);
    chk("R10 psc cleared", count_now(), 16'h0100);
    cyc(1);
    chk("R10 first step", count_now(), 16'h0101);
    cfg_psc = 2'd0;
    load(16'h00FF);
    chk("R10 write wins", count_now(), 16'h00FF);

    // R11 R12 R13 byte access
    base_cfg(); cfg_on = 1'b0;
    load(16'h0000);
    cfg_rd16 = 1'b1;
    wr_hi = 1'b1; bus_wdata = 8'h12; cyc(1); wr_hi = 1'b0;
    rd_lo = 1'b1; cyc(1); rd_lo = 1'b0;
    chk("R12 hi buffered only", count_now(), 16'h0000);
    wr_lo = 1'b1; bus_wdata = 8'hFE; cyc(1); wr_lo = 1'b0;
    chk("R11 stale latch", count_now(), 16'h00FE);
    rd_lo = 1'b1; cyc(1); rd_lo = 1'b0;
    chk("R12 atomic load", count_now(), 16'h12FE);
    cfg_on = 1'b1;
    cyc(2);
    cfg_on = 1'b0;
    chk("R11 latch holds", count_now(), 16'h1200);
    cfg_on = 1'b1;
    rd_lo = 1'b1; cyc(1); rd_lo = 1'b0; cfg_on = 1'b0;
    chk("R11 relatch", count_now(), 16'h1301);
    cfg_rd16 = 1'b0;
    #1;
    chk("R13 live high", count_now(), 16'h1301);
    wr_hi = 1'b1; bus_wdata = 8'hAB; cyc(1); wr_hi = 1'b0;
    chk("R13 direct hi write", count_now(), 16'hAB01);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule